// File: doc/BRIEF.md
# Page Write Collector and Commit Sequencer

This block sits between the serial protocol engine and the storage array of a two-wire memory. When the engine opens a write transfer it hands over the starting address. Each data byte it then receives goes into a page-sized holding buffer, at the slot named by the low bits of an address pointer. Only those low bits advance after each byte. They wrap inside the page, so a transfer longer than a page overwrites its own earlier bytes.

Nothing reaches the array while the transfer is open. When the engine reports a clean Stop, the block raises `busy` for a fixed number of system clock cycles, `WRITE_CYCLES`, which stands in for the self-timed programming time. During the first page-length stretch of that window it walks the buffer in ascending slot order. It issues one array write for every slot that actually received a byte, so untouched slots keep their old contents. While `busy` is high, every input from the engine is ignored. A Start that arrives before Stop, or a Stop that cuts a byte short, is reported on `bus_abort`; it throws the buffer away and starts no write cycle.

Top module: `page_commit_buffer`

## Requirements
- R1: After reset, `busy` and `mem_we` are 0 and `addr_ptr` is 0.
- R2: A pulse on `xfer_start` while not busy loads `addr_ptr` from `start_addr` and opens a transfer. Bytes and Stops that arrive while no transfer is open are ignored.
- R3: Each accepted byte is stored at page slot `addr_ptr[PAGE_W-1:0]`. Only those low bits then increment, wrapping from 255 to 0; the upper address bits never change.
- R4: When more than 256 bytes arrive before Stop, a later byte replaces the earlier byte held at the same slot, and only the latest value is committed.
- R5: No array write happens before Stop. The cycle after a Stop is accepted with at least one byte buffered, `busy` rises and stays high for exactly `WRITE_CYCLES` cycles.
- R6: In busy cycle k, for k < 256, `mem_we` is 1 exactly when slot k received a byte. In that cycle `mem_addr` is {page bits of `addr_ptr`, k} and `mem_wdata` is that slot's byte.
- R7: While `busy` is high, `xfer_start`, `byte_valid`, `bus_stop` and `bus_abort` have no effect on the array writes, on `addr_ptr`, or on the length of the busy window.
- R8: `bus_abort` during an open transfer discards all buffered bytes, closes the transfer and starts no write cycle. It has priority over every other input in the same cycle.
- R9: A Stop with no data byte buffered closes the transfer without raising `busy`.
- R10: A byte and a Stop in the same cycle: the byte is buffered and included in the commit.
- R11: After a write transfer, `addr_ptr` holds the slot after the last byte written, within the same page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xfer_start | input | 1 | Pulse: a write transfer opens, address valid |
| start_addr | input | ADDR_W | Starting array address of the transfer |
| byte_valid | input | 1 | Pulse: a data byte has been received |
| byte_data | input | DATA_W | Received data byte |
| bus_stop | input | 1 | Pulse: clean Stop condition |
| bus_abort | input | 1 | Pulse: restart before Stop, or Stop cutting a byte short |
| busy | output | 1 | Internal write cycle in progress |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | ADDR_W | Array write address |
| mem_wdata | output | DATA_W | Array write data |
| addr_ptr | output | ADDR_W | Current address pointer |

## Verification
Two functions can fall in the same cycle: accepting the last data byte, and accepting the Stop that commits the buffer. The bench drives `byte_valid` and `bus_stop` together on one edge. It then expects that byte's slot to be written during the busy window and the pointer to land one slot past it. The same collision with `bus_abort` in place of Stop, and with any input while `busy` is high, is judged by comparing busy, the write strobe, address, data and pointer against a behavioural model on every clock.

// File: rtl/page_commit_buffer.sv
module page_commit_buffer #(
  parameter int ADDR_W       = 17,
  parameter int PAGE_W       = 8,
  parameter int DATA_W       = 8,
  parameter int WRITE_CYCLES = 500000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer_start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              byte_valid,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              bus_stop,
  input  logic              bus_abort,
  output logic              busy,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [ADDR_W-1:0] addr_ptr
);
  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int CNT_W      = $clog2(WRITE_CYCLES + 1);

  typedef enum logic [1:0] {S_IDLE, S_FILL, S_PROG} state_t;

  state_t                 state_q;
  logic [DATA_W-1:0]      page_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0]  have_q;
  logic [CNT_W-1:0]       cnt_q;

  wire [PAGE_W-1:0] slot     = addr_ptr[PAGE_W-1:0];
  wire [PAGE_W-1:0] scan     = cnt_q[PAGE_W-1:0];
  wire              scanning = (state_q == S_PROG) && (cnt_q < CNT_W'(PAGE_BYTES));
  wire              take     = (state_q == S_FILL) && byte_valid && !bus_abort && !xfer_start;
  wire              any_byte = (|have_q) || take;

  assign busy      = (state_q == S_PROG);
  assign mem_we    = scanning && have_q[scan];
  assign mem_addr  = {addr_ptr[ADDR_W-1:PAGE_W], scan};
  assign mem_wdata = page_q[scan];

  always_ff @(posedge clk) begin
    if (take) page_q[slot] <= byte_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      have_q   <= '0;
      addr_ptr <= '0;
      cnt_q    <= '0;
    end else begin
      case (state_q)
        S_IDLE: begin
          if (xfer_start && !bus_abort) begin
            addr_ptr <= start_addr;
            have_q   <= '0;
            state_q  <= S_FILL;
          end
        end
        S_FILL: begin
          if (bus_abort) begin
            have_q  <= '0;
            state_q <= S_IDLE;
          end else if (xfer_start) begin
            addr_ptr <= start_addr;
            have_q   <= '0;
          end else begin
            if (take) begin
              have_q[slot]            <= 1'b1;
              addr_ptr[PAGE_W-1:0]    <= slot + 1'b1;
            end
            if (bus_stop) begin
              cnt_q   <= '0;
              state_q <= any_byte ? S_PROG : S_IDLE;
            end
          end
        end
        S_PROG: begin
          if (cnt_q == CNT_W'(WRITE_CYCLES - 1)) begin
            have_q  <= '0;
            state_q <= S_IDLE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  initial assert (WRITE_CYCLES >= PAGE_BYTES)
    else $error("WRITE_CYCLES must cover one scan of the page");

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> !busy && !mem_we && addr_ptr == '0);

  assert_no_early_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);

  assert_stop_commits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_FILL && bus_stop && !bus_abort && !xfer_start && any_byte) |=> busy);

  assert_empty_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_FILL && bus_stop && !bus_abort && !xfer_start && !any_byte) |=> !busy);

  assert_abort_no_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && bus_abort) |=> !busy);

  assert_ptr_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(addr_ptr));

  assert_page_fixed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> addr_ptr[ADDR_W-1:PAGE_W] == $past(addr_ptr[ADDR_W-1:PAGE_W]));
endmodule

// File: tb/page_commit_buffer_bench.sv
module page_commit_buffer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 17;
  localparam int WC = 300;

  logic          clk = 0, rst_n = 0;
  logic          xs = 0, bv = 0, st = 0, ab = 0;
  logic [AW-1:0] sa = '0;
  logic [7:0]    bd = '0;
  logic          busy, mem_we;
  logic [AW-1:0] mem_addr, addr_ptr;
  logic [7:0]    mem_wdata;

  page_commit_buffer #(.ADDR_W(AW), .PAGE_W(8), .DATA_W(8), .WRITE_CYCLES(WC)) u_page_commit_buffer (
    .clk(clk), .rst_n(rst_n), .xfer_start(xs), .start_addr(sa), .byte_valid(bv),
    .byte_data(bd), .bus_stop(st), .bus_abort(ab), .busy(busy), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .addr_ptr(addr_ptr));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0, writes = 0, cycles = 0;
  logic [7:0] dut_mem [int];

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  logic [7:0] m_pend [int];
  bit         m_open = 0, m_prog = 0;
  int         m_cnt = 0;
  int         m_ptr = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pend.delete(); m_open = 0; m_prog = 0; m_cnt = 0; m_ptr = 0;
    end else if (m_prog) begin
      if (m_cnt == WC - 1) begin m_prog = 0; m_pend.delete(); end
      else m_cnt++;
    end else if (ab) begin
      m_open = 0; m_pend.delete();
    end else if (xs) begin
      m_ptr = int'(sa); m_open = 1; m_pend.delete();
    end else if (m_open) begin
      if (bv) begin
        m_pend[m_ptr % 256] = bd;
        m_ptr = (m_ptr / 256) * 256 + ((m_ptr + 1) % 256);
      end
      if (st) begin
        m_open = 0;
        if (m_pend.num() > 0) begin m_prog = 1; m_cnt = 0; end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      bit exp_we;
      exp_we = m_prog && m_cnt < 256 && m_pend.exists(m_cnt);
      check(busy == m_prog, "R5/R7 busy", busy, m_prog);
      check(mem_we == exp_we, "R6 mem_we", mem_we, exp_we);
      if (exp_we) begin
        check(int'(mem_addr) == (m_ptr / 256) * 256 + m_cnt, "R6 mem_addr", mem_addr, (m_ptr / 256) * 256 + m_cnt);
        check(mem_wdata == m_pend[m_cnt], "R6 mem_wdata", mem_wdata, m_pend[m_cnt]);
      end
      check(int'(addr_ptr) == m_ptr, "R3/R11 addr_ptr", addr_ptr, m_ptr);
      if (mem_we) begin dut_mem[int'(mem_addr)] = mem_wdata; writes++; end
    end
  end

  task automatic tick(); @(negedge clk); xs = 0; bv = 0; st = 0; ab = 0; endtask
  task automatic do_start(input int a); xs = 1; sa = AW'(a); tick(); endtask
  task automatic do_byte(input logic [7:0] d, input bit with_stop = 0); bv = 1; bd = d; st = with_stop; tick(); endtask
  task automatic do_stop(); st = 1; tick(); endtask
  task automatic wait_done(output int n); n = 0; while (busy) begin n++; @(negedge clk); end endtask

  function automatic logic [7:0] memv(input int a);
    return dut_mem.exists(a) ? dut_mem[a] : 8'hxx;
  endfunction

  initial begin
    int n, w0;
    repeat (3) @(negedge clk);
    check(busy == 0 && mem_we == 0 && addr_ptr == 0, "R1 reset state", {busy, mem_we, addr_ptr}, 0);
    rst_n = 1; @(negedge clk);

    // single byte write
    do_start('h12345); do_byte(8'hA5); do_stop();
    wait_done(n);
    check(n == WC, "R5 busy length", n, WC);
    check(memv('h12345) == 8'hA5, "R5 single byte commit", memv('h12345), 8'hA5);
    check(addr_ptr == 'h12346, "R11 pointer after write", addr_ptr, 'h12346);

    // wrap inside page
    w0 = writes;
    do_start('h001FE); do_byte(8'h11); do_byte(8'h22); do_byte(8'h33); do_byte(8'h44); do_stop();
    wait_done(n);
    check(memv('h100) == 8'h33, "R3 wrap to slot 0", memv('h100), 8'h33);
    check(memv('h101) == 8'h44, "R3 wrap slot 1", memv('h101), 8'h44);
    check(!dut_mem.exists('h200), "R3 no page crossing", dut_mem.exists('h200), 0);
    check(writes - w0 == 4, "R6 only received slots", writes - w0, 4);
    check(addr_ptr == 'h00102, "R11 pointer wrapped", addr_ptr, 'h00102);

    // overrun past one page
    w0 = writes;
    do_start('h00310);
    for (int i = 0; i < 258; i++) do_byte(i >= 256 ? 8'hE0 + 8'(i - 256) : 8'(i));
    do_stop();
    wait_done(n);
    check(memv('h310) == 8'hE0, "R4 overwrite slot 10", memv('h310), 8'hE0);
    check(memv('h311) == 8'hE1, "R4 overwrite slot 11", memv('h311), 8'hE1);
    check(memv('h312) == 8'h02, "R4 keep slot 12", memv('h312), 8'h02);
    check(writes - w0 == 256, "R6 full page count", writes - w0, 256);
    check(addr_ptr == 'h00312, "R11 pointer after overrun", addr_ptr, 'h00312);

    // abort discards
    do_start('h00500); do_byte(8'h01); do_byte(8'h02); ab = 1; bv = 1; bd = 8'h03; tick();
    repeat (3) begin check(busy == 0, "R8 no cycle after abort", busy, 0); @(negedge clk); end
    do_stop();
    check(busy == 0 && !dut_mem.exists('h500), "R8 buffer discarded", busy, 0);

    // inputs ignored while busy
    do_start('h00600); do_byte(8'h66); do_stop();
    do_start('h00700); do_byte(8'h77); do_stop(); ab = 1; tick();
    wait_done(n);
    check(n + 4 == WC, "R7 busy length unchanged", n + 4, WC);
    check(memv('h600) == 8'h66 && !dut_mem.exists('h700), "R7 no write from busy inputs", memv('h600), 8'h66);
    check(addr_ptr == 'h00601, "R7 pointer untouched", addr_ptr, 'h00601);

    // byte and stop on the same edge
    do_start('h00800); do_byte(8'h81); do_byte(8'h82, 1);
    check(busy == 1, "R10 stop with byte commits", busy, 1);
    wait_done(n);
    check(memv('h801) == 8'h82, "R10 last byte included", memv('h801), 8'h82);
    check(addr_ptr == 'h00802, "R10 pointer", addr_ptr, 'h00802);

    // stray byte with no transfer, then empty transfer
    do_byte(8'h99); do_stop();
    check(busy == 0 && addr_ptr == 'h00802, "R2 idle inputs ignored", addr_ptr, 'h00802);
    do_start('h00900);
    check(addr_ptr == 'h00900, "R2 pointer loaded", addr_ptr, 'h00900);
    do_stop();
    check(busy == 0, "R9 empty stop no cycle", busy, 0);
    repeat (2) @(negedge clk);
    check(busy == 0 && addr_ptr == 'h00900, "R9 stays idle", addr_ptr, 'h00900);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk); cycles++;
      if (cycles > 50000) begin
        checks++; fails++;
        $display("FAIL watchdog actual=%0d expected=<50000", cycles);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    end
  end
endmodule